// File: doc/BRIEF.md
# Preamble-Inserting Frame Builder

Each time it is started, the block assembles one fixed-length output frame. The frame opens with a stored synchronisation preamble made of two back-to-back 13-bit Barker sequences. The block then draws payload samples one at a time from an upstream FIFO, using a read strobe that it drives itself, and writes each sample straight to a downstream FIFO. Both the input and the output may stall the frame. During a stall the block holds its place in the frame and loses nothing.

Control uses a start input, an idle output and a one-cycle done pulse. The upstream FIFO is show-ahead: `src_data` is valid whenever `src_empty` is low, and a word is taken on a clock edge where `src_rd` is high. The downstream FIFO accepts `dst_data` on a clock edge where `dst_wr` is high.

Top module: `frame_builder`

## Requirements
- R1: After synchronous reset, `idle` is 1, `done` is 0, and both `src_rd` and `dst_wr` are 0.
- R2: When `start` is sampled high while `idle` is 1, the frame begins. In the next cycle `idle` is 0, and `dst_wr` is high unless `dst_full` is high.
- R3: The first 26 writes of a frame carry the preamble {1111100110101, 1111100110101}, leftmost bit first. `src_rd` stays 0 during these writes.
- R4: Writes 27 to 200 carry 174 payload samples. For each of them `src_rd` and `dst_wr` are high in the same cycle, and `dst_data` equals `src_data`.
- R5: While `dst_full` is 1, `dst_wr` and `src_rd` are 0, and the block keeps its position in the frame.
- R6: In the payload part of the frame, while `src_empty` is 1, `src_rd` and `dst_wr` are 0, and the block keeps its position in the frame.
- R7: `done` is high for exactly one cycle, in the cycle after the 200th write. In that same cycle `idle` is 1.
- R8: A `start` sampled while a frame is in progress has no effect. The frame still has exactly 200 writes and the usual content, and once it ends the block stays idle.
- R9: When `DATA_W` is greater than 1, a preamble bit 1 is written as +1 and a preamble bit 0 as -1, both in two's complement. Payload words pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one frame; taken only while idle |
| idle | output | 1 | High when no frame is in progress |
| done | output | 1 | One-cycle pulse after the last write of a frame |
| src_data | input | DATA_W | Head word of the upstream FIFO |
| src_empty | input | 1 | Upstream FIFO has no word |
| src_rd | output | 1 | Pops the head word of the upstream FIFO |
| dst_data | output | DATA_W | Sample written downstream |
| dst_full | input | 1 | Downstream FIFO cannot accept a word |
| dst_wr | output | 1 | Writes `dst_data` downstream |

## Verification
Back-pressure from the output and starvation at the input can both occur in the same payload cycle. The bench drives `dst_full` and `src_empty` from two independent pseudo-random patterns, so they overlap in many cycles, including around the boundary between preamble and payload. The bench then judges that no read or write occurs and that the next accepted sample is the right one in the frame. A held `start` also lands in the very cycle that `done` pulses. The bench checks that a second frame begins at once with a fresh preamble and that neither frame gains or loses a sample.

// File: rtl/fb_pkg.sv
package fb_pkg;

    // One 13-bit Barker sequence, leftmost bit sent first
    localparam logic [12:0] BARKER13 = 13'b1111100110101;
    localparam int unsigned BARKER_LEN = 13;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SYNC = 2'd1,
        PH_BODY = 2'd2
    } phase_t;

    // Sync bit as a signed sample: +1 for 1, -1 for 0 (single bit passes as is)
    function automatic logic [31:0] sync_level(input logic b, input int unsigned w);
        if (w == 1)
            return {31'd0, b};
        return b ? 32'd1 : 32'hFFFF_FFFF;
    endfunction

endpackage

// File: rtl/fb_sync_rom.sv
module fb_sync_rom #(
    parameter int unsigned DATA_W   = 1,
    parameter int unsigned SYNC_REP = 2,
    parameter int unsigned POS_W    = 8
) (
    input  logic [POS_W-1:0]  pos,
    output logic [DATA_W-1:0] sample
);
    import fb_pkg::*;

    localparam int unsigned SYNC_LEN = BARKER_LEN * SYNC_REP;
    localparam logic [SYNC_LEN-1:0] PATTERN = {SYNC_REP{BARKER13}};

    logic bit_now;

    always_comb begin
        bit_now = 1'b0;
        for (int i = 0; i < SYNC_LEN; i++) begin
            if (int'(pos) == i)
                bit_now = PATTERN[SYNC_LEN-1-i];
        end
    end

    generate
        if (DATA_W == 1) begin : g_bit
            assign sample = bit_now;
        end else begin : g_word
            logic [31:0] lvl;
            assign lvl    = sync_level(bit_now, DATA_W);
            assign sample = lvl[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/fb_sequencer.sv
module fb_sequencer #(
    parameter int unsigned SYNC_LEN  = 26,
    parameter int unsigned FRAME_LEN = 200,
    parameter int unsigned POS_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             dst_full,
    input  logic             src_empty,
    output fb_pkg::phase_t   phase,
    output logic [POS_W-1:0] pos,
    output logic             fire,
    output logic             done
);
    import fb_pkg::*;

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] SYNC_END = POS_W'(SYNC_LEN - 1);

    phase_t phase_q;
    logic [POS_W-1:0] pos_q;
    logic done_q;

    always_comb begin
        unique case (phase_q)
            PH_SYNC: fire = !dst_full;
            PH_BODY: fire = !dst_full && !src_empty;
            default: fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            pos_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase_q == PH_IDLE) begin
                if (start) begin
                    phase_q <= PH_SYNC;
                    pos_q   <= '0;
                end
            end else if (fire) begin
                if (pos_q == LAST_POS) begin
                    phase_q <= PH_IDLE;
                    pos_q   <= '0;
                    done_q  <= 1'b1;
                end else begin
                    pos_q <= pos_q + 1'b1;
                    if (pos_q == SYNC_END)
                        phase_q <= PH_BODY;
                end
            end
        end
    end

    assign phase = phase_q;
    assign pos   = pos_q;
    assign done  = done_q;

    // R5
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && !fire) |=> ($stable(pos_q) && $stable(phase_q)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (phase_q == PH_IDLE));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && start && !fire) |=> (phase_q != PH_IDLE));

endmodule

// File: rtl/frame_builder.sv
module frame_builder #(
    parameter int unsigned DATA_W   = 1,
    parameter int unsigned SYNC_REP = 2,
    parameter int unsigned BODY_LEN = 174
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              idle,
    output logic              done,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_empty,
    output logic              src_rd,
    output logic [DATA_W-1:0] dst_data,
    input  logic              dst_full,
    output logic              dst_wr
);
    import fb_pkg::*;

    localparam int unsigned SYNC_LEN  = BARKER_LEN * SYNC_REP;
    localparam int unsigned FRAME_LEN = SYNC_LEN + BODY_LEN;
    localparam int unsigned POS_W     = $clog2(FRAME_LEN);

    phase_t phase;
    logic [POS_W-1:0] pos;
    logic fire;
    logic [DATA_W-1:0] sync_word;

    fb_sequencer #(
        .SYNC_LEN (SYNC_LEN),
        .FRAME_LEN(FRAME_LEN),
        .POS_W    (POS_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dst_full (dst_full),
        .src_empty(src_empty),
        .phase    (phase),
        .pos      (pos),
        .fire     (fire),
        .done     (done)
    );

    fb_sync_rom #(
        .DATA_W  (DATA_W),
        .SYNC_REP(SYNC_REP),
        .POS_W   (POS_W)
    ) u_rom (
        .pos   (pos),
        .sample(sync_word)
    );

    assign idle     = (phase == PH_IDLE);
    assign dst_wr   = fire;
    assign src_rd   = fire && (phase == PH_BODY);
    assign dst_data = (phase == PH_BODY) ? src_data : sync_word;

    // R4
    rd_with_wr_chk: assert property (@(posedge clk) disable iff (rst)
        src_rd |-> (dst_wr && !src_empty));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        dst_full |-> (!dst_wr && !src_rd));

    // R3
    no_sync_read_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SYNC) |-> !src_rd);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!dst_wr && !src_rd));

endmodule

// File: tb/frame_builder_test.sv
module frame_builder_test;

    localparam int SYNC = 26;
    localparam int BODY = 174;
    localparam int FLEN = 200;
    localparam logic [25:0] PRE = {2{13'b1111100110101}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic src_empty = 1'b0;
    logic dst_full = 1'b0;
    logic idle, done, src_rd, dst_wr, dst_data;
    logic idle_w, done_w, src_rd_w, dst_wr_w;
    logic [3:0] dst_data_w;

    int rd_ptr = 0;
    int src_frame = 0;
    logic [0:0] src_data;
    logic [3:0] src_data_w;

    int checks = 0;
    int fails = 0;
    int frames_done = 0;
    bit stall_en = 1'b0;
    bit done_pending = 1'b0;

    // item: {rd expected, wide word, narrow bit}
    logic [5:0] exp_q[$];

    always #5 clk = ~clk;

    function automatic logic pay_bit(int f, int i);
        logic [7:0] v;
        v = 8'(i) ^ 8'(f * 29 + 3);
        return ^v;
    endfunction

    assign src_data   = pay_bit(src_frame, rd_ptr);
    assign src_data_w = {3'(rd_ptr), src_data};

    frame_builder uut (
        .clk(clk), .rst(rst), .start(start), .idle(idle), .done(done),
        .src_data(src_data), .src_empty(src_empty), .src_rd(src_rd),
        .dst_data(dst_data), .dst_full(dst_full), .dst_wr(dst_wr)
    );

    frame_builder #(.DATA_W(4)) uut_w (
        .clk(clk), .rst(rst), .start(start), .idle(idle_w), .done(done_w),
        .src_data(src_data_w), .src_empty(src_empty), .src_rd(src_rd_w),
        .dst_data(dst_data_w), .dst_full(dst_full), .dst_wr(dst_wr_w)
    );

    always @(posedge clk) begin
        if (!rst && src_rd) begin
            if (rd_ptr == BODY - 1) begin
                rd_ptr    <= 0;
                src_frame <= src_frame + 1;
            end else begin
                rd_ptr <= rd_ptr + 1;
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // driver: queue the expected content of one frame
    task automatic push_frame(int f);
        for (int i = 0; i < FLEN; i++) begin
            logic b;
            logic [3:0] w;
            if (i < SYNC) begin
                b = PRE[SYNC - 1 - i];
                w = b ? 4'd1 : 4'hF;
                exp_q.push_back({1'b0, w, b});
            end else begin
                b = pay_bit(f, i - SYNC);
                w = {3'(i - SYNC), b};
                exp_q.push_back({1'b1, w, b});
            end
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (done_pending) begin
                check(done == 1'b1 && idle == 1'b1, "R7", {30'd0, idle, done}, 3);
                frames_done++;
            end else if (done) begin
                check(1'b0, "R7", 1, 0);
            end
            done_pending = 1'b0;
            check(dst_wr == dst_wr_w && src_rd == src_rd_w && done == done_w,
                  "R9", {29'd0, dst_wr_w, src_rd_w, done_w}, {29'd0, dst_wr, src_rd, done});
            if (dst_full)
                check(!dst_wr && !src_rd, "R5", {30'd0, dst_wr, src_rd}, 0);
            if (dst_wr) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", 1, 0);
                end else begin
                    logic [5:0] e;
                    e = exp_q.pop_front();
                    if (e[5])
                        check(dst_data == e[0], "R4", dst_data, e[0]);
                    else
                        check(dst_data == e[0], "R3", dst_data, e[0]);
                    check(src_rd == e[5], e[5] ? "R4" : "R3", src_rd, e[5]);
                    if (e[5]) check(!src_empty, "R6", src_empty, 0);
                    check(dst_data_w == e[4:1], "R9", dst_data_w, e[4:1]);
                    if ((exp_q.size() % FLEN) == 0) done_pending = 1'b1;
                end
            end
        end
    end

    // stall pattern generator
    initial begin
        logic [15:0] lf = 16'hACE1;
        forever begin
            @(posedge clk);
            #1;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (stall_en) begin
                dst_full  = (lf[2:0] == 3'd0) || (lf[7:5] == 3'd3);
                src_empty = (lf[10:8] == 3'd1) || (lf[13:11] == 3'd6);
            end else begin
                dst_full  = 1'b0;
                src_empty = 1'b0;
            end
        end
    end

    task automatic wait_frames(int n);
        while (frames_done < n) @(posedge clk);
    endtask

    // watchdog
    initial begin
        #1500000;
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        check(idle && !done && !src_rd && !dst_wr, "R1",
              {28'd0, idle, done, src_rd, dst_wr}, 8);

        // frame 0: no stalls
        push_frame(0);
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        // R2
        check(!idle && dst_wr, "R2", {30'd0, idle, dst_wr}, 1);
        wait_frames(1);

        // frame 1: stalls on both sides plus starts while busy
        push_frame(1);
        stall_en = 1'b1;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        for (int k = 0; k < 6; k++) begin
            repeat (37) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        wait_frames(2);
        repeat (12) @(negedge clk)
            // R8
            check(idle && !dst_wr, "R8", {30'd0, idle, dst_wr}, 2);

        // frames 2 and 3: start held, back to back through the done cycle
        push_frame(2);
        push_frame(3);
        @(posedge clk); #1 start = 1'b1;
        wait_frames(3);
        @(posedge clk); #1 start = 1'b0;
        wait_frames(4);
        stall_en = 1'b0;
        repeat (10) @(negedge clk)
            // R7
            check(idle && !dst_wr && !done, "R7", {29'd0, idle, dst_wr, done}, 4);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule